// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block is a small, fully associative buffer of recent page translations. Each lookup presents a virtual address, the current address-space identifier and an access kind (read or write). The virtual page number and identifier are compared with every resident entry at the same time. On a match, the stored frame number is joined to the untranslated 12-bit page offset to form the physical address. The entry's permission is checked against the access kind. Each entry keeps its own use and modified flags, and the buffer updates them on every successful access.

A lookup that finds no entry is reported as a miss. The buffer does not try to resolve it. An outside handler finds the translation and installs it through the install port. Installation fills the lowest empty slot first. Once every slot is occupied, a rotating pointer picks which slot is overwritten. Results appear on the clock edge after the lookup is presented.

Top module: `tlb_xlate`

## Requirements
- R1: After reset every slot is empty. The result outputs are all low, and any lookup reports a miss.
- R2: A lookup hits only when a valid slot matches the virtual page number (address bits above 11) and the identifier matches exactly. A slot with the same page but a different identifier does not hit.
- R3: On a hit, `paddr` equals the slot's frame number in bits 31:12 and the lookup's address bits 11:0 in bits 11:0. When `hit` is low, `paddr` is zero.
- R4: The result appears in the cycle after `lk_valid` is sampled. Exactly one of `hit`, `miss` and `prot_fault` is high for each lookup, and none of them is high in a cycle that follows no lookup.
- R5: A write lookup that matches a slot holding read-only permission (`wr_rw`=0 at install) raises `prot_fault` instead of `hit`. It leaves that slot's use and modified flags unchanged.
- R6: For a hit or fault, `ref_seen` and `dirty_seen` show the slot's use and modified flags as they were before the access. A successful access sets the use flag, and a successful write also sets the modified flag.
- R7: An install writes the lowest-numbered empty slot, marks it valid and clears its use and modified flags.
- R8: When every slot is valid, an install replaces the slot chosen by a rotating pointer. The pointer starts at 0 after reset, advances by one only on such full-buffer installs, and wraps after the last slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_write | input | 1 | Lookup is a write access |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_asid | input | 8 | Current address-space identifier |
| wr_en | input | 1 | Install a translation |
| wr_vpn | input | 20 | Virtual page number to install |
| wr_asid | input | 8 | Identifier to install |
| wr_pfn | input | 20 | Physical frame number to install |
| wr_rw | input | 1 | 1: read/write permission, 0: read only |
| hit | output | 1 | Lookup translated |
| miss | output | 1 | No slot matched |
| prot_fault | output | 1 | Write to a read-only page |
| paddr | output | 32 | Physical address on hit |
| ref_seen | output | 1 | Slot use flag before this access |
| dirty_seen | output | 1 | Slot modified flag before this access |

## Verification
A corrupted slot field shows at the ports on the next lookup that reaches that slot. A wrong tag or identifier turns a hit into a miss, and a wrong frame gives a bad `paddr`, one cycle after the lookup. A wrong use or modified flag shows in `ref_seen` or `dirty_seen` on the next access to the same slot. A wrong replacement pointer stays hidden until the buffer is full, and then shows as a miss on an address that should still be resident. For this reason the sweep fills the buffer, touches every slot under both identifiers and both access kinds, and then forces two evictions.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    typedef enum logic [1:0] {
        RES_NONE  = 2'd0,
        RES_HIT   = 2'd1,
        RES_MISS  = 2'd2,
        RES_FAULT = 2'd3
    } tlb_res_e;
endpackage

// File: rtl/tlb_cam_match.sv
module tlb_cam_match #(
    parameter int ENTRIES = 4,
    parameter int VPN_W   = 20,
    parameter int ASID_W  = 8,
    parameter int IDX_W   = 2
) (
    input  logic [ENTRIES-1:0]             vld,
    input  logic [ENTRIES-1:0][VPN_W-1:0]  vpn_tab,
    input  logic [ENTRIES-1:0][ASID_W-1:0] asid_tab,
    input  logic [VPN_W-1:0]               key_vpn,
    input  logic [ASID_W-1:0]              key_asid,
    output logic [ENTRIES-1:0]             hit_vec,
    output logic                           any,
    output logic [IDX_W-1:0]               idx
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = vld[g] && (vpn_tab[g] == key_vpn) && (asid_tab[g] == key_asid);
    end

    assign any = |hit_vec;

    always_comb begin
        idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) idx = idx | IDX_W'(i);
        end
    end
endmodule

// File: rtl/tlb_victim_pick.sv
module tlb_victim_pick #(
    parameter int ENTRIES = 4,
    parameter int IDX_W   = 2
) (
    input  logic [ENTRIES-1:0] vld,
    input  logic [IDX_W-1:0]   rr,
    output logic [IDX_W-1:0]   victim
);
    always_comb begin
        victim = rr;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!vld[i]) victim = IDX_W'(i);
        end
    end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
    import tlb_pkg::*;
#(
    parameter int VA_W    = 32,
    parameter int PA_W    = 32,
    parameter int OFF_W   = 12,
    parameter int ASID_W  = 8,
    parameter int ENTRIES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  lk_valid,
    input  logic                  lk_write,
    input  logic [VA_W-1:0]       lk_vaddr,
    input  logic [ASID_W-1:0]     lk_asid,
    input  logic                  wr_en,
    input  logic [VA_W-OFF_W-1:0] wr_vpn,
    input  logic [ASID_W-1:0]     wr_asid,
    input  logic [PA_W-OFF_W-1:0] wr_pfn,
    input  logic                  wr_rw,
    output logic                  hit,
    output logic                  miss,
    output logic                  prot_fault,
    output logic [PA_W-1:0]       paddr,
    output logic                  ref_seen,
    output logic                  dirty_seen
);
    localparam int VPN_W = VA_W - OFF_W;
    localparam int PFN_W = PA_W - OFF_W;
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        logic              vld;
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic [PFN_W-1:0]  pfn;
        logic              rw;
        logic              ref_b;
        logic              dirty;
    } ent_t;

    typedef struct packed {
        ent_t [ENTRIES-1:0] ent;
        logic [IDX_W-1:0]   rr;
        tlb_res_e           res;
        logic [PA_W-1:0]    pa;
        logic               ref_o;
        logic               dirty_o;
    } st_t;

    st_t st_q, st_d;

    logic [ENTRIES-1:0]             vld_v;
    logic [ENTRIES-1:0][VPN_W-1:0]  vpn_v;
    logic [ENTRIES-1:0][ASID_W-1:0] asid_v;
    logic [ENTRIES-1:0]             hit_vec;
    logic                           any_match;
    logic [IDX_W-1:0]               match_idx;
    logic [IDX_W-1:0]               victim;
    ent_t                           sel;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_tab
        assign vld_v[g]  = st_q.ent[g].vld;
        assign vpn_v[g]  = st_q.ent[g].vpn;
        assign asid_v[g] = st_q.ent[g].asid;
    end

    tlb_cam_match #(
        .ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .IDX_W(IDX_W)
    ) u_match (
        .vld      (vld_v),
        .vpn_tab  (vpn_v),
        .asid_tab (asid_v),
        .key_vpn  (lk_vaddr[VA_W-1:OFF_W]),
        .key_asid (lk_asid),
        .hit_vec  (hit_vec),
        .any      (any_match),
        .idx      (match_idx)
    );

    tlb_victim_pick #(
        .ENTRIES(ENTRIES), .IDX_W(IDX_W)
    ) u_victim (
        .vld    (vld_v),
        .rr     (st_q.rr),
        .victim (victim)
    );

    always_comb begin
        st_d         = st_q;
        st_d.res     = RES_NONE;
        st_d.pa      = '0;
        st_d.ref_o   = 1'b0;
        st_d.dirty_o = 1'b0;
        sel          = st_q.ent[match_idx];

        if (lk_valid) begin
            if (any_match) begin
                st_d.ref_o   = sel.ref_b;
                st_d.dirty_o = sel.dirty;
                if (lk_write && !sel.rw) begin
                    st_d.res = RES_FAULT;
                end else begin
                    st_d.res                  = RES_HIT;
                    st_d.pa                   = {sel.pfn, lk_vaddr[OFF_W-1:0]};
                    st_d.ent[match_idx].ref_b = 1'b1;
                    if (lk_write) st_d.ent[match_idx].dirty = 1'b1;
                end
            end else begin
                st_d.res = RES_MISS;
            end
        end

        if (wr_en) begin
            st_d.ent[victim].vld   = 1'b1;
            st_d.ent[victim].vpn   = wr_vpn;
            st_d.ent[victim].asid  = wr_asid;
            st_d.ent[victim].pfn   = wr_pfn;
            st_d.ent[victim].rw    = wr_rw;
            st_d.ent[victim].ref_b = 1'b0;
            st_d.ent[victim].dirty = 1'b0;
            if (&vld_v) begin
                st_d.rr = (st_q.rr == IDX_W'(ENTRIES - 1)) ? '0 : st_q.rr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.res <= RES_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign hit        = (st_q.res == RES_HIT);
    assign miss       = (st_q.res == RES_MISS);
    assign prot_fault = (st_q.res == RES_FAULT);
    assign paddr      = st_q.pa;
    assign ref_seen   = st_q.ref_o;
    assign dirty_seen = st_q.dirty_o;
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
    parameter int VA_W    = 32,
    parameter int PA_W    = 32,
    parameter int OFF_W   = 12,
    parameter int ASID_W  = 8,
    parameter int ENTRIES = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid,
    input logic              lk_write,
    input logic [VA_W-1:0]   lk_vaddr,
    input logic              hit,
    input logic              miss,
    input logic              prot_fault,
    input logic [PA_W-1:0]   paddr
);
    // R4
    one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> $countones({hit, miss, prot_fault}) == 1);

    // R4
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !(hit || miss || prot_fault));

    // R3
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (!hit || paddr[OFF_W-1:0] == $past(lk_vaddr[OFF_W-1:0])));

    // R3
    paddr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> paddr == '0);

    // R5
    fault_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid && !lk_write |=> !prot_fault);
endmodule

bind tlb_xlate tlb_xlate_chk #(
    .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .ASID_W(ASID_W), .ENTRIES(ENTRIES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_valid   (lk_valid),
    .lk_write   (lk_write),
    .lk_vaddr   (lk_vaddr),
    .hit        (hit),
    .miss       (miss),
    .prot_fault (prot_fault),
    .paddr      (paddr)
);

// File: tb/tlb_xlate_test.sv
module tlb_xlate_test;
    localparam int CLK_P = 10;
    localparam int N     = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0, lk_write = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [7:0]  lk_asid = '0;
    logic        wr_en = 1'b0, wr_rw = 1'b0;
    logic [19:0] wr_vpn = '0, wr_pfn = '0;
    logic [7:0]  wr_asid = '0;
    logic        hit, miss, prot_fault, ref_seen, dirty_seen;
    logic [31:0] paddr;

    int checks = 0;
    int errors = 0;

    logic [19:0] m_vpn [N];
    logic [7:0]  m_asid[N];
    logic [19:0] m_pfn [N];
    logic        m_rw[N], m_ref[N], m_dirty[N], m_vld[N];
    int          m_rr = 0;

    always #(CLK_P/2) clk = ~clk;

    tlb_xlate uut (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_write(lk_write),
        .lk_vaddr(lk_vaddr), .lk_asid(lk_asid), .wr_en(wr_en), .wr_vpn(wr_vpn),
        .wr_asid(wr_asid), .wr_pfn(wr_pfn), .wr_rw(wr_rw), .hit(hit), .miss(miss),
        .prot_fault(prot_fault), .paddr(paddr), .ref_seen(ref_seen), .dirty_seen(dirty_seen)
    );

    task automatic chk(input bit ok, input string req, input logic [36:0] act, input logic [36:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic install(input logic [19:0] vpn, input logic [7:0] asid,
                           input logic [19:0] pfn, input logic rw);
        int slot;
        slot = -1;
        for (int i = N - 1; i >= 0; i--) if (!m_vld[i]) slot = i;
        if (slot < 0) begin
            slot = m_rr;
            m_rr = (m_rr + 1) % N;
        end
        m_vld[slot] = 1'b1; m_vpn[slot] = vpn; m_asid[slot] = asid;
        m_pfn[slot] = pfn; m_rw[slot] = rw; m_ref[slot] = 1'b0; m_dirty[slot] = 1'b0;
        @(negedge clk);
        wr_en = 1'b1; wr_vpn = vpn; wr_asid = asid; wr_pfn = pfn; wr_rw = rw;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic look(input logic [31:0] va, input logic [7:0] asid, input logic wr);
        int          idx;
        logic [36:0] exp, act;
        string       req;
        idx = -1;
        for (int i = 0; i < N; i++)
            if (m_vld[i] && m_vpn[i] == va[31:12] && m_asid[i] == asid) idx = i;
        if (idx < 0) begin
            exp = {3'b010, 32'h0, 2'b00};
            req = "R2";
        end else if (wr && !m_rw[idx]) begin
            exp = {3'b001, 32'h0, m_ref[idx], m_dirty[idx]};
            req = "R5";
        end else begin
            exp = {3'b100, m_pfn[idx], va[11:0], m_ref[idx], m_dirty[idx]};
            req = (m_ref[idx] || m_dirty[idx]) ? "R6" : "R3";
            m_ref[idx] = 1'b1;
            if (wr) m_dirty[idx] = 1'b1;
        end
        @(negedge clk);
        lk_valid = 1'b1; lk_vaddr = va; lk_asid = asid; lk_write = wr;
        @(negedge clk);
        lk_valid = 1'b0;
        act = {hit, miss, prot_fault, paddr, ref_seen, dirty_seen};
        chk(act === exp, req, act, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_vld[i] = 1'b0; m_ref[i] = 1'b0; m_dirty[i] = 1'b0;
            m_rw[i] = 1'b0; m_vpn[i] = '0; m_asid[i] = '0; m_pfn[i] = '0;
        end
        repeat (3) @(negedge clk);
        // R1: outputs low out of reset
        chk({hit, miss, prot_fault, paddr} === 35'h0, "R1",
            {2'b0, hit, miss, prot_fault, paddr}, 37'h0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: empty buffer misses
        look(32'h0000_1234, 8'h00, 1'b0);
        look(32'hFFFF_F000, 8'h3C, 1'b1);
        // R4: idle cycle shows no result
        @(negedge clk);
        chk(!(hit || miss || prot_fault), "R4", {34'h0, hit, miss, prot_fault}, 37'h0);

        // R7: fill slots in order
        for (int s = 0; s < N; s++)
            install(20'(s * 3 + 1), 8'(8'h10 + s), 20'(20'h80 + s * 5), logic'(s % 2));

        // R2 R3 R5 R6: sweep slots, identifier, access kind, offset
        for (int rep = 0; rep < 2; rep++)
            for (int s = 0; s < N; s++)
                for (int a = 0; a < 2; a++)
                    for (int w = 0; w < 2; w++)
                        look({20'(s * 3 + 1), 12'((s * 12'h111 + w * 7 + rep * 12'h800) & 12'hFFF)},
                             a ? 8'(8'h10 + s) ^ 8'h5A : 8'(8'h10 + s), logic'(w));

        // R4: unmapped page misses
        look(32'h0002_0ABC, 8'h10, 1'b0);

        // R8: two full-buffer installs replace slot 0 then slot 1
        install(20'h00777, 8'h22, 20'hABCDE, 1'b1);
        install(20'h00888, 8'h23, 20'h12345, 1'b0);
        look(32'h0000_1FFF, 8'h10, 1'b0);
        look(32'h0000_4001, 8'h11, 1'b0);
        look(32'h0077_7010, 8'h22, 1'b1);
        look(32'h0088_8020, 8'h23, 1'b1);
        look(32'h0000_7555, 8'h12, 1'b0);
        look(32'h0077_7FFF, 8'h22, 1'b0);
        finish_run();
    end
endmodule